// File: doc/BRIEF.md
# Dual-Width Shift Unit with Carry

This block is a single-stage shift unit for a 64-bit execution datapath. Each accepted operation is one of three kinds: a left shift, a right shift, or a sign-extend-then-shift-left. A right shift is logical or arithmetic depending on a signed flag. A width flag selects 32-bit or 64-bit operation.

The shift amount is taken from the low bits of a full-width amount register. In 64-bit mode seven amount bits are used, so amounts from 64 to 127 push every source bit out of the word. An arithmetic right shift also reports, on a two-bit carry field, whether a negative value lost any one bits.

The datapath itself is combinational. Its result, its carry, the operation code and a caller-supplied tag are captured in one register stage. An output valid marks each captured operation one cycle after its input valid.

Top module: `dshift_unit`

## Requirements
- R1: Left shift (op code 2'b00) with the width flag high shifts by the low 6 bits of the amount register. Only bits 31:0 of the result are kept, and bits 63:32 are zero.
- R2: Left shift with the width flag low shifts by the low 7 bits of the amount register. Amounts from 64 to 127 give a zero result.
- R3: Right shift (op code 2'b01) with the signed flag low is a logical shift. With the width flag high, source bits 31:0 are zero-extended and shifted by the low 6 amount bits. With the width flag low, the whole source is shifted by the low 7 amount bits, and amounts of 64 or more give zero.
- R4: Right shift with the signed flag high is an arithmetic shift that produces a 64-bit result. With the width flag high, source bits 31:0 are sign-extended to 64 bits and shifted by the low 6 amount bits. With the width flag low, the source is shifted by the low 7 amount bits. An amount at or beyond the operand width fills the result with the sign bit.
- R5: For an arithmetic right shift, the carry is 1 exactly when the extended source is negative and at least one 1 bit is shifted out. That carry is driven onto both bits of the 2-bit carry output.
- R6: Left shifts, logical right shifts, the sign-extend-shift and the unused op code all give a carry output of 2'b00.
- R7: Sign-extend-shift (op code 2'b10) sign-extends source bits 31:0 to 64 bits, then shifts left by the low 6 amount bits. The width flag has no effect on it.
- R8: Op code 2'b11 is unused and gives a zero result.
- R9: The output valid is high in the cycle after an input valid and low in the cycle after a cycle with no input valid. With each valid result, the op code and tag of that operation appear unchanged.
- R10: While reset is high, the output valid, result, carry, op code and tag are all zero after the next clock edge.
- R11: A cycle with the input valid low leaves the result, carry, op code and tag outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_src | input | 64 | Source operand |
| in_amt | input | 64 | Shift amount register; only low bits are used |
| in_op | input | 2 | 00 left, 01 right, 10 sign-extend-shift, 11 unused |
| in_w32 | input | 1 | 1 selects 32-bit operation |
| in_signed | input | 1 | 1 makes a right shift arithmetic |
| in_tag | input | TAG_W | Caller tag echoed with the result |
| out_valid | output | 1 | Result registers hold a new operation |
| out_result | output | 64 | Shift result |
| out_carry | output | 2 | Replicated carry |
| out_op | output | 2 | Echoed op code |
| out_tag | output | TAG_W | Echoed tag |

## Verification
The bench builds the unit with its default parameters: a 64-bit word, and a tag of 4 bits, so the echo check covers all tag values. Amounts are drawn across the whole 0 to 127 range of the 7-bit field, with extra weight near 31, 32, 63 and 64. This covers the flush and sign-fill cases and the 32-bit truncation edges. It also makes sure the high amount bits above the used field are ignored. Negative sources with and without low one bits separate the two carry outcomes.

// File: rtl/shf_pkg.sv
`timescale 1ns/1ps
package shf_pkg;
    localparam int XLEN   = 64;
    localparam int HALF   = XLEN / 2;
    localparam int SH_W   = $clog2(XLEN);
    localparam int AMT_W  = SH_W + 1;
    localparam int CARRY_W = 2;

    typedef enum logic [1:0] {
        SOP_SHL  = 2'd0,
        SOP_SHR  = 2'd1,
        SOP_SXSL = 2'd2,
        SOP_NONE = 2'd3
    } shf_op_e;

    typedef struct packed {
        logic [XLEN-1:0]  opnd;
        logic [AMT_W-1:0] amt;
        shf_op_e          op;
        logic             w32;
        logic             arith;
    } shf_prep_t;

    function automatic logic [XLEN-1:0] sext_half(input logic [HALF-1:0] v);
        return {{HALF{v[HALF-1]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] zext_half(input logic [HALF-1:0] v);
        return {{HALF{1'b0}}, v};
    endfunction
endpackage

// File: rtl/shf_prep.sv
`timescale 1ns/1ps
module shf_prep
    import shf_pkg::*;
(
    input  logic [XLEN-1:0] src,
    input  logic [XLEN-1:0] amt_reg,
    input  shf_op_e         op,
    input  logic            w32,
    input  logic            sgn,
    output shf_prep_t       prep
);
    logic unused_amt_hi;
    assign unused_amt_hi = ^amt_reg[XLEN-1:AMT_W];

    logic [AMT_W-1:0] amt_narrow;
    logic [AMT_W-1:0] amt_wide;
    assign amt_narrow = {1'b0, amt_reg[SH_W-1:0]};
    assign amt_wide   = amt_reg[AMT_W-1:0];

    always_comb begin
        prep       = '0;
        prep.op    = op;
        prep.w32   = w32;
        prep.arith = (op == SOP_SHR) && sgn;
        case (op)
            SOP_SHL: begin
                prep.opnd = src;
                prep.amt  = w32 ? amt_narrow : amt_wide;
            end
            SOP_SHR: begin
                if (w32) begin
                    prep.opnd = sgn ? sext_half(src[HALF-1:0]) : zext_half(src[HALF-1:0]);
                    prep.amt  = amt_narrow;
                end else begin
                    prep.opnd = src;
                    prep.amt  = amt_wide;
                end
            end
            SOP_SXSL: begin
                prep.opnd = sext_half(src[HALF-1:0]);
                prep.amt  = amt_narrow;
            end
            default: begin
                prep.opnd = '0;
                prep.amt  = '0;
            end
        endcase
    end
endmodule

// File: rtl/shf_core.sv
`timescale 1ns/1ps
module shf_core
    import shf_pkg::*;
(
    input  shf_prep_t       prep,
    output logic [XLEN-1:0] result,
    output logic            carry
);
    logic            flush;
    logic [SH_W-1:0] sh;
    logic            sign;
    logic [XLEN-1:0] lost_mask;

    assign flush     = prep.amt[AMT_W-1];
    assign sh        = prep.amt[SH_W-1:0];
    assign sign      = prep.opnd[XLEN-1];
    assign lost_mask = flush ? {XLEN{1'b1}} : ~({XLEN{1'b1}} << sh);

    always_comb begin
        result = '0;
        case (prep.op)
            SOP_SHL, SOP_SXSL: begin
                result = flush ? '0 : (prep.opnd << sh);
                if (prep.op == SOP_SHL && prep.w32)
                    result[XLEN-1:HALF] = '0;
            end
            SOP_SHR: begin
                if (prep.arith)
                    result = flush ? {XLEN{sign}} : XLEN'($signed(prep.opnd) >>> sh);
                else
                    result = flush ? '0 : (prep.opnd >> sh);
            end
            default: result = '0;
        endcase
    end

    assign carry = prep.arith && sign && (|(prep.opnd & lost_mask));
endmodule

// File: rtl/shf_outreg.sv
`timescale 1ns/1ps
module shf_outreg
    import shf_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [XLEN-1:0]    in_result,
    input  logic               in_carry,
    input  shf_op_e            in_op,
    input  logic [TAG_W-1:0]   in_tag,
    output logic               out_valid,
    output logic [XLEN-1:0]    out_result,
    output logic [CARRY_W-1:0] out_carry,
    output shf_op_e            out_op,
    output logic [TAG_W-1:0]   out_tag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_result <= '0;
            out_carry  <= '0;
            out_op     <= SOP_SHL;
            out_tag    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result <= in_result;
                out_carry  <= {CARRY_W{in_carry}};
                out_op     <= in_op;
                out_tag    <= in_tag;
            end
        end
    end

    assert_valid_follow_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_valid_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_tag_echo_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_tag == $past(in_tag)) && (out_op == $past(in_op)));
    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_result) && $stable(out_carry) && $stable(out_tag));
endmodule

// File: rtl/dshift_unit.sv
`timescale 1ns/1ps
module dshift_unit
    import shf_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [XLEN-1:0]    in_src,
    input  logic [XLEN-1:0]    in_amt,
    input  logic [1:0]         in_op,
    input  logic               in_w32,
    input  logic               in_signed,
    input  logic [TAG_W-1:0]   in_tag,
    output logic               out_valid,
    output logic [XLEN-1:0]    out_result,
    output logic [CARRY_W-1:0] out_carry,
    output logic [1:0]         out_op,
    output logic [TAG_W-1:0]   out_tag
);
    shf_prep_t       prep;
    logic [XLEN-1:0] core_res;
    logic            core_carry;
    shf_op_e         op_q;

    shf_prep u_prep (
        .src     (in_src),
        .amt_reg (in_amt),
        .op      (shf_op_e'(in_op)),
        .w32     (in_w32),
        .sgn     (in_signed),
        .prep    (prep)
    );

    shf_core u_core (
        .prep   (prep),
        .result (core_res),
        .carry  (core_carry)
    );

    shf_outreg #(.TAG_W(TAG_W)) u_oreg (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_result  (core_res),
        .in_carry   (core_carry),
        .in_op      (shf_op_e'(in_op)),
        .in_tag     (in_tag),
        .out_valid  (out_valid),
        .out_result (out_result),
        .out_carry  (out_carry),
        .out_op     (op_q),
        .out_tag    (out_tag)
    );

    assign out_op = op_q;

    assert_carry_only_shr_R6: assert property (@(posedge clk) disable iff (rst)
        (out_carry != '0) |-> (out_op == SOP_SHR));
    assert_carry_pair_R5: assert property (@(posedge clk) disable iff (rst)
        out_carry[0] == out_carry[1]);
    assert_w32_left_upper_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == SOP_SHL && in_w32) |=> (out_result[XLEN-1:HALF] == '0));
    assert_unused_op_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == SOP_NONE) |=> (out_result == '0));
endmodule

// File: tb/dshift_unit_tb_top.sv
`timescale 1ns/1ps
module dshift_unit_tb_top;
    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [63:0]   in_src = '0;
    logic [63:0]   in_amt = '0;
    logic [1:0]    in_op = '0;
    logic          in_w32 = 1'b0;
    logic          in_signed = 1'b0;
    logic [TW-1:0] in_tag = '0;
    logic          out_valid;
    logic [63:0]   out_result;
    logic [1:0]    out_carry;
    logic [1:0]    out_op;
    logic [TW-1:0] out_tag;

    always #2 clk = ~clk;

    dshift_unit #(.TAG_W(TW)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_src(in_src), .in_amt(in_amt),
        .in_op(in_op), .in_w32(in_w32), .in_signed(in_signed), .in_tag(in_tag),
        .out_valid(out_valid), .out_result(out_result), .out_carry(out_carry),
        .out_op(out_op), .out_tag(out_tag)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic          e_valid = 0;
    logic [63:0]   e_res = '0;
    logic [1:0]    e_car = '0;
    logic [1:0]    e_op = '0;
    logic [TW-1:0] e_tag = '0;
    string         e_rtag = "R10";
    string         e_ctag = "R10";
    bit            e_after_idle = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void model(input logic [63:0] a, input logic [63:0] b, input logic [1:0] op,
                                  input logic w32, input logic sg,
                                  output logic [63:0] r, output logic [1:0] c);
        logic [127:0] s, q;
        int n;
        c = 2'b00;
        r = '0;
        case (op)
            2'd0: begin
                n = w32 ? int'(b[5:0]) : int'(b[6:0]);
                s = {64'b0, a};
                q = s << n;
                r = q[63:0];
                if (w32) r[63:32] = '0;
            end
            2'd1: begin
                n = w32 ? int'(b[5:0]) : int'(b[6:0]);
                if (sg) s = w32 ? {{96{a[31]}}, a[31:0]} : {{64{a[63]}}, a};
                else    s = w32 ? {96'b0, a[31:0]} : {64'b0, a};
                if (sg) q = $signed(s) >>> n;
                else    q = s >> n;
                r = q[63:0];
                if (sg && s[127] && ((q << n) != s)) c = 2'b11;
            end
            2'd2: begin
                n = int'(b[5:0]);
                s = {{96{a[31]}}, a[31:0]};
                q = s << n;
                r = q[63:0];
            end
            default: r = '0;
        endcase
    endfunction

    function automatic string rtag(input logic [1:0] op, input logic w32, input logic sg);
        case (op)
            2'd0: return w32 ? "R1" : "R2";
            2'd1: return sg ? "R4" : "R3";
            2'd2: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic compare_now();
        chk(e_after_idle ? "R9 idle" : "R9 valid", {63'b0, out_valid}, {63'b0, e_valid});
        if (e_valid) begin
            chk(e_rtag, out_result, e_res);
            chk(e_ctag, {62'b0, out_carry}, {62'b0, e_car});
            chk("R9 op echo", {62'b0, out_op}, {62'b0, e_op});
            chk("R9 tag echo", {60'b0, out_tag}, {60'b0, e_tag});
        end else begin
            chk("R11 hold result", out_result, e_res);
            chk("R11 hold tag", {60'b0, out_tag}, {60'b0, e_tag});
        end
    endtask

    task automatic apply(input logic v, input logic [63:0] a, input logic [63:0] b,
                         input logic [1:0] op, input logic w32, input logic sg, input logic [TW-1:0] t);
        logic [63:0] r;
        logic [1:0]  c;
        @(negedge clk);
        compare_now();
        in_valid = v; in_src = a; in_amt = b; in_op = op; in_w32 = w32; in_signed = sg; in_tag = t;
        e_valid = v;
        e_after_idle = !v;
        if (v) begin
            model(a, b, op, w32, sg, r, c);
            e_res = r; e_car = c; e_op = op; e_tag = t;
            e_rtag = rtag(op, w32, sg);
            e_ctag = (op == 2'd1 && sg) ? "R5" : "R6";
        end
    endtask

    function automatic logic [63:0] pick_amt();
        logic [63:0] hi;
        int k;
        hi = {$urandom, $urandom};
        k = $urandom_range(0, 9);
        case (k)
            0: return {hi[63:7], 7'd31};
            1: return {hi[63:7], 7'd32};
            2: return {hi[63:7], 7'd63};
            3: return {hi[63:7], 7'd64};
            4: return {hi[63:7], 7'd0};
            default: return hi;
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 valid", {63'b0, out_valid}, 64'd0);
        chk("R10 result", out_result, 64'd0);
        chk("R10 carry", {62'b0, out_carry}, 64'd0);
        chk("R10 tag", {60'b0, out_tag}, 64'd0);
        rst = 1'b0;
        // directed corners
        apply(1, 64'h0000_0000_8000_0001, 64'd1,   2'd0, 1, 0, 4'h1); // R1 truncation
        apply(1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd40,  2'd0, 1, 0, 4'h2); // R1 amt>=32
        apply(1, 64'h1, 64'd64,  2'd0, 0, 0, 4'h3);                   // R2 flush
        apply(1, 64'h1, 64'd63,  2'd0, 0, 0, 4'h4);                   // R2 edge
        apply(1, 64'hFFFF_FFFF_8000_0000, 64'd31, 2'd1, 1, 0, 4'h5);  // R3 zext
        apply(1, 64'h8000_0000_0000_0000, 64'd100, 2'd1, 0, 0, 4'h6); // R3 flush
        apply(1, 64'h0000_0000_8000_0000, 64'd4, 2'd1, 1, 1, 4'h7);   // R4 sext no loss
        apply(1, 64'h0000_0000_8000_0010, 64'd5, 2'd1, 1, 1, 4'h8);   // R5 loss
        apply(1, 64'h8000_0000_0000_0000, 64'd127, 2'd1, 0, 1, 4'h9); // R4 fill, R5
        apply(1, 64'h7FFF_FFFF_FFFF_FFFF, 64'd70, 2'd1, 0, 1, 4'hA);  // R4 positive flush
        apply(0, 64'hDEAD, 64'd3, 2'd0, 0, 0, 4'hF);                  // R11 idle
        apply(1, 64'h0000_0000_8000_0003, 64'hFF00_0000_0000_0044, 2'd2, 1, 1, 4'hB); // R7
        apply(1, 64'h0000_0000_8000_0003, 64'd4, 2'd2, 0, 0, 4'hC);   // R7 flag ignored
        apply(1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd5, 2'd3, 0, 1, 4'hD);   // R8
        for (int i = 0; i < 4000; i++) begin
            logic [63:0] a;
            a = {$urandom, $urandom};
            if ($urandom_range(0, 3) == 0) a[31:0] = {1'b1, 31'd0};
            apply($urandom_range(0, 4) != 0, a, pick_amt(), 2'($urandom_range(0, 3)),
                  1'($urandom), 1'($urandom), 4'($urandom));
        end
        apply(0, 64'd0, 64'd0, 2'd0, 0, 0, 4'h0);
        @(negedge clk);
        compare_now();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 190000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog run hung actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule